// File: doc/BRIEF.md
# Bank Output Clock Divider

This block derives one output clock from a bank clock. It takes an 8-bit control word, made of a select bit and a 7-bit divide code, and picks one of four behaviours. With the code at its all-ones value, the select bit either stops the divider or passes the bank clock straight through. With any smaller code, the select bit picks a fixed halving or an even ratio of `(code + 2) * 2`. The largest such ratio is 256. Every divided output has a 50% duty cycle. A half-period counter drives a toggle stage to produce it.

When the divider is stopped it stays powered but makes no edges. A separate 2-bit output-enable mode then sets the output: driven low, driven high, or released. A released output appears as a low enable flag, not as a real three-state pad. A control word that arrives while the divider runs waits for the next rising edge of the output before it takes effect, so a change of ratio never produces a runt pulse. A synchronous active-low reset clears the counters and holds the output low.

Top module: `bank_clk_divider`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low and `out_en` is high. After release, a divider that was programmed during reset gives its first rising output edge on the H-th clock edge, where H is the half period in input cycles.
- R2: Select 0 with code 127 stops the divider, and no edges appear. Output-enable mode 00 then drives `clk_out` low and mode 01 drives it high, with `out_en` high in both cases.
- R3: While the divider is stopped, output-enable mode 10 or 11 deasserts `out_en` and holds `clk_out` low. The mode field acts on the outputs within the same cycle.
- R4: Select 1 with code 127 passes the input clock through: `clk_out` is high while `clk` is high and low while `clk` is low.
- R5: Select 0 with a code below 127 divides by 2 (H = 1).
- R6: Select 1 with a code below 127 divides by `(code + 2) * 2`. The output stays high for H = code + 2 input cycles and low for H cycles. Code 0 gives ratio 4 and code 126 gives ratio 256.
- R7: While a divide mode runs, a new control word is held back until the clock edge at which the output would next rise. Until that edge the old waveform continues unchanged.
- R8: From the stopped or pass-through state, a new word takes effect at the next clock edge. A divide mode started this way keeps the output low for H cycles and then rises.
- R9: When a word is applied at a rising-edge boundary and selects a divide mode, the output rises at that edge and stays high for the new H cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| div_sel | input | 1 | Select bit of the control word |
| div_code | input | 7 | Divide code of the control word |
| oe_mode | input | 2 | Output level while stopped: 00 low, 01 high, 1x released |
| clk_out | output | 1 | Divided or passed-through clock |
| out_en | output | 1 | Output-enable flag; low means released |

## Verification
Each result has a fixed latency. The output-enable mode acts on the outputs in the same cycle. A word given while the divider is stopped or passing through becomes active at the next clock edge. A divide started from idle gives its first rising edge H+1 edges after the word is given. A word given while dividing becomes active only at the edge where the output would next rise, and the bench computes that edge from the running ratio and phase. The driver places inputs on falling edges and pushes one expected output pair per coming rising edge. The monitor samples 1 ns after each rising edge, while `clk` is still high, so every sample falls inside a settled cycle. The low phase of pass-through is checked separately, just after a falling edge.

// File: rtl/clkdiv_pkg.sv
// Package: shared encodings for the bank clock divider.
// Assumes: output-enable mode is a 2-bit field; bit 1 set means released.
package clkdiv_pkg;
    // Active behaviour selected by the control word.
    typedef enum logic [1:0] {
        DM_OFF  = 2'd0,
        DM_BYP  = 2'd1,
        DM_DIV2 = 2'd2,
        DM_DIVN = 2'd3
    } div_mode_e;

    localparam logic [1:0] OE_DRIVE_LOW  = 2'b00;
    localparam logic [1:0] OE_DRIVE_HIGH = 2'b01;
endpackage

// File: rtl/clkdiv_word_decode.sv
// Module: turns the select bit and divide code into a mode and a half period.
// Assumes: the all-ones code is reserved for the stop and pass-through choices;
// the half-period width is one bit wider than the code, so code+2 always fits.
module clkdiv_word_decode #(
    parameter int CODE_W = 7,
    localparam int HALF_W = CODE_W + 1
) (
    input  logic                     sel,
    input  logic [CODE_W-1:0]        code,
    output clkdiv_pkg::div_mode_e    mode,
    output logic [HALF_W-1:0]        half
);
    import clkdiv_pkg::*;

    logic code_full;

    // Detect the reserved all-ones code.
    always_comb code_full = &code;

    // Map the word onto a mode and its half period in input cycles.
    always_comb begin
        half = HALF_W'(1);
        if (code_full) begin
            mode = sel ? DM_BYP : DM_OFF;
        end else if (!sel) begin
            mode = DM_DIV2;
        end else begin
            mode = DM_DIVN;
            half = {1'b0, code} + HALF_W'(2);
        end
    end
endmodule

// File: rtl/clkdiv_core.sv
// Module: half-period counter plus toggle stage, with the active settings.
// Assumes: half is never zero; a new setting is taken each cycle while idle,
// and only at the would-rise edge while a divide mode runs.
module clkdiv_core #(
    parameter int HALF_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  clkdiv_pkg::div_mode_e new_mode,
    input  logic [HALF_W-1:0]     new_half,
    output clkdiv_pkg::div_mode_e act_mode,
    output logic                  tgl
);
    import clkdiv_pkg::*;

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] act_half;
    logic              running;
    logic              last;
    logic              new_runs;

    // Classify the active and the requested modes.
    always_comb begin
        running  = (act_mode == DM_DIV2) || (act_mode == DM_DIVN);
        new_runs = (new_mode == DM_DIV2) || (new_mode == DM_DIVN);
        last     = (cnt == act_half - HALF_W'(1));
    end

    // Count half periods, toggle, and take new settings at the safe point.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            cnt      <= '0;
            tgl      <= 1'b0;
            act_mode <= new_mode;
            act_half <= new_half;
        end else if (last) begin
            cnt <= '0;
            if (!tgl) begin
                act_mode <= new_mode;
                act_half <= new_half;
                tgl      <= new_runs;
            end else begin
                tgl <= 1'b0;
            end
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < act_half));

    // R6
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !last) |=> $stable(tgl));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(last && !tgl)) |=> ($stable(act_mode) && $stable(act_half)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (!tgl && cnt == '0));
endmodule

// File: rtl/clkdiv_out_stage.sv
// Module: selects what reaches the output pin and its enable flag.
// Assumes: the output-enable mode acts at once; reset forces a low, driven output.
module clkdiv_out_stage (
    input  logic                  clk,
    input  logic                  rst_n,
    input  clkdiv_pkg::div_mode_e act_mode,
    input  logic                  tgl,
    input  logic [1:0]            oe_mode,
    output logic                  clk_out,
    output logic                  out_en
);
    import clkdiv_pkg::*;

    // Pick the output source for the active mode.
    always_comb begin
        out_en  = 1'b1;
        clk_out = 1'b0;
        if (rst_n) begin
            unique case (act_mode)
                DM_OFF: begin
                    out_en  = !oe_mode[1];
                    clk_out = (oe_mode == OE_DRIVE_HIGH);
                end
                DM_BYP:  clk_out = clk;
                default: clk_out = tgl;
            endcase
        end
    end

    // R3
    released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !clk_out);
endmodule

// File: rtl/bank_clk_divider.sv
// Module: top of the bank output clock divider.
// Assumes: control inputs are synchronous to clk; reset is synchronous, active low.
module bank_clk_divider #(
    parameter int CODE_W = 7,
    localparam int HALF_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_sel,
    input  logic [CODE_W-1:0] div_code,
    input  logic [1:0]        oe_mode,
    output logic              clk_out,
    output logic              out_en
);
    import clkdiv_pkg::*;

    div_mode_e         req_mode;
    div_mode_e         act_mode;
    logic [HALF_W-1:0] req_half;
    logic              tgl;

    clkdiv_word_decode #(.CODE_W(CODE_W)) u_decode (
        .sel  (div_sel),
        .code (div_code),
        .mode (req_mode),
        .half (req_half)
    );

    clkdiv_core #(.HALF_W(HALF_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_mode (req_mode),
        .new_half (req_half),
        .act_mode (act_mode),
        .tgl      (tgl)
    );

    clkdiv_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_mode (act_mode),
        .tgl      (tgl),
        .oe_mode  (oe_mode),
        .clk_out  (clk_out),
        .out_en   (out_en)
    );
endmodule

// File: tb/test_bank_clk_divider.sv
`timescale 1ns/1ps
module test_bank_clk_divider;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       div_sel;
    logic [6:0] div_code;
    logic [1:0] oe_mode;
    logic       clk_out;
    logic       out_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct { logic c; logic e; int r; } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    bank_clk_divider i_bank_clk_divider (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .div_code(div_code),
        .oe_mode(oe_mode), .clk_out(clk_out), .out_en(out_en)
    );

    task automatic check(logic gc, logic ge, logic ec, logic ee, int r);
        checks++;
        if (gc !== ec || ge !== ee) begin
            errors++;
            $display("FAIL R%0d at %0t: clk_out/out_en got %b/%b expected %b/%b",
                     r, $time, gc, ge, ec, ee);
        end
    endtask

    task automatic drive(bit sel, int code, logic [1:0] oe);
        div_sel  = sel;
        div_code = code[6:0];
        oe_mode  = oe;
    endtask

    task automatic push_lvl(logic c, logic e, int r, int n);
        for (int k = 0; k < n; k++) begin
            exp_t x;
            x.c = c; x.e = e; x.r = r;
            sb.push_back(x);
        end
    endtask

    // Expected divided output: sample index j gives ((j / h) % 2) xor start.
    task automatic push_div(int h, bit st, int j0, int n, int r);
        for (int k = 0; k < n; k++) begin
            exp_t x;
            x.c = ((((j0 + k) / h) % 2) != 0) ^ st;
            x.e = 1'b1; x.r = r;
            sb.push_back(x);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops one expected pair per rising edge, samples while clk is high.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                check(clk_out, out_en, x.c, x.e, x.r);
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got running expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1, 0, 2'b00);                 // ratio 4, H = 2
        @(negedge clk);
        // R1 output low while reset is held
        push_lvl(0, 1, 1, 6);
        wait_n(6);
        rst_n = 1'b1;
        // R1 first rise on the H-th edge after release
        push_div(2, 0, 1, 8, 1);
        wait_n(8);
        // R2 stop with level high; old waveform ends at the would-rise edge
        drive(0, 127, 2'b01);
        push_div(2, 0, 9, 1, 7);
        push_lvl(1, 1, 2, 5);
        wait_n(6);
        // R2 stopped, driven low
        drive(0, 127, 2'b00);
        push_lvl(0, 1, 2, 4);
        wait_n(4);
        // R3 released output for both encodings
        drive(0, 127, 2'b10);
        push_lvl(0, 0, 3, 3);
        wait_n(3);
        drive(0, 127, 2'b11);
        push_lvl(0, 0, 3, 3);
        wait_n(3);
        // R4 pass-through, high phase via monitor
        drive(1, 127, 2'b10);
        push_lvl(1, 1, 4, 6);
        wait_n(6);
        #1;
        check(clk_out, out_en, 1'b0, 1'b1, 4);   // R4 low phase follows clk
        // R5 divide by two, started from pass-through (R8 timing)
        drive(0, 5, 2'b00);
        push_div(1, 0, 0, 10, 5);
        wait_n(10);
        // R9 switch to ratio 4 at the boundary, rises there
        drive(1, 0, 2'b00);
        push_div(1, 0, 10, 1, 7);
        push_div(2, 1, 0, 12, 9);
        wait_n(13);
        // R6 code 126 gives ratio 256, high 128 then low 128
        drive(1, 126, 2'b00);
        push_div(128, 1, 0, 520, 6);
        wait_n(520);
        // R7 change during the high phase is held until the next would-rise edge
        drive(0, 3, 2'b00);
        push_div(128, 1, 520, 248, 7);
        push_div(1, 1, 0, 6, 7);
        wait_n(254);
        // R7 stop at the boundary, low level proves it was applied there
        drive(0, 127, 2'b00);
        push_lvl(0, 1, 7, 4);
        wait_n(4);
        // R8 start code 1 (ratio 6) from stopped: low for 3, then high for 3
        drive(1, 1, 2'b00);
        push_div(3, 0, 0, 14, 8);
        wait_n(14);
        // R4 pass-through taken at the boundary
        drive(1, 127, 2'b00);
        push_div(3, 0, 14, 1, 7);
        push_lvl(1, 1, 4, 4);
        wait_n(5);
        // R1 reset in mid-operation forces low output
        rst_n = 1'b0;
        push_lvl(0, 1, 1, 3);
        wait_n(3);
        wait (sb.size() == 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule